// File: doc/BRIEF.md
# Bus Trigger Mode Engine

This block watches a processor bus one cycle at a time. It compares each valid cycle against two programmable comparators, A and B, and raises trigger events according to a selected trigger mode. A debug or trace controller sits around it. That controller programs the comparators, the mode and the read/write qualifiers, then holds `enable` high for the length of a run. It consumes the `trig` pulses, and in the event-only modes it also consumes the `capture` pulses and the captured data byte.

Comparator A is always an address comparator. Comparator B is an address comparator in most modes. In the two full modes only its low data-width bits are used, and they are compared against the data byte. Each comparator can also require the read/write flag to equal a programmed value. Two sticky flags record whether A and B have matched since the run was armed. The A flag also serves as the "A already seen" state of the two sequential modes.

Top module: `bus_trigger_engine`

## Requirements
- R1: Every output is registered. A condition met on a cycle with `bus_valid`=1 and `enable`=1 shows on `trig` one clock later, as a one-cycle pulse for each such cycle. A cycle with `bus_valid`=0 produces no trigger, capture or flag change. Mode 0 triggers on an A match. Mode 1 triggers on an A match or a B match.
- R2: Mode 2 triggers on a B match only if `hit_a` was already set before that cycle. An A match in an earlier cycle enables it, with any number of cycles in between. An A match in the same cycle does not.
- R3: Mode 3 triggers when A matches the address and `bus_data` equals `cmp_b[DW-1:0]` in the same cycle. Mode 4 triggers when A matches and `bus_data` differs from `cmp_b[DW-1:0]` in the same cycle. In both modes the upper bits of `cmp_b` and the B read/write qualifier have no effect.
- R4: Mode 7 triggers when `cmp_a <= bus_addr <= cmp_b` (unsigned, inclusive). Mode 8 triggers when `bus_addr < cmp_a` or `bus_addr > cmp_b`. Both modes use the A read/write qualifier.
- R5: Mode 5 raises `trig` and `capture` on every B match. Mode 6 does the same once `hit_a` is set. On each capture, `capture_data` holds the data byte of the matching cycle. `capture` is never raised in any other mode.
- R6: An A match means `bus_addr == cmp_a`, and also `bus_rd == qual_a_rd` when `qual_a_en`=1. A B match is defined the same way with `cmp_b`, `qual_b_en` and `qual_b_rd`. `bus_rd`=1 denotes a read.
- R7: Mode codes 9 through 15 never raise `trig` or `capture`.
- R8: `hit_a` and `hit_b` become set after a cycle with an A (or B) match and stay set while `enable`=1. While `enable`=0 both flags and all pulses are cleared, so re-arming starts from clear flags and a cleared sequential state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run armed; low clears all state |
| mode | input | 4 | Trigger mode code 0..15 |
| cmp_a | input | AW | Comparator A address |
| cmp_b | input | AW | Comparator B address; low DW bits are data in full modes |
| qual_a_en | input | 1 | Qualify A with read/write |
| qual_a_rd | input | 1 | Required read/write value for A |
| qual_b_en | input | 1 | Qualify B with read/write |
| qual_b_rd | input | 1 | Required read/write value for B |
| bus_valid | input | 1 | Bus cycle strobe |
| bus_addr | input | AW | Bus address |
| bus_data | input | DW | Bus data byte |
| bus_rd | input | 1 | 1 = read, 0 = write |
| trig | output | 1 | Trigger pulse |
| capture | output | 1 | Event-only capture pulse |
| capture_data | output | DW | Data of last captured cycle |
| hit_a | output | 1 | Sticky A matched |
| hit_b | output | 1 | Sticky B matched |

## Verification
The bench builds the block with a 4-bit address and a 3-bit data word. At these widths every address and every data value can be swept against each of the sixteen mode codes, for both bus directions. Comparator pairs with A below B, A above B, A equal to B and the full extremes exercise the empty, single-point and full inclusive ranges. Each mode sweep starts from a fresh arm, and the addresses are visited in order. Because of this, the sequential modes see B matches both before and after the first A match.

// File: rtl/bus_trigger_engine.sv
module bus_trigger_engine #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] cmp_a,
  input  logic [AW-1:0] cmp_b,
  input  logic          qual_a_en,
  input  logic          qual_a_rd,
  input  logic          qual_b_en,
  input  logic          qual_b_rd,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_rd,
  output logic          trig,
  output logic          capture,
  output logic [DW-1:0] capture_data,
  output logic          hit_a,
  output logic          hit_b
);

  localparam logic [3:0] M_A      = 4'd0;
  localparam logic [3:0] M_A_OR_B = 4'd1;
  localparam logic [3:0] M_A_THEN = 4'd2;
  localparam logic [3:0] M_FULL   = 4'd3;
  localparam logic [3:0] M_FULL_N = 4'd4;
  localparam logic [3:0] M_EV_B   = 4'd5;
  localparam logic [3:0] M_EV_AB  = 4'd6;
  localparam logic [3:0] M_IN     = 4'd7;
  localparam logic [3:0] M_OUT    = 4'd8;

  wire rw_ok_a  = !qual_a_en || (bus_rd == qual_a_rd);
  wire rw_ok_b  = !qual_b_en || (bus_rd == qual_b_rd);
  wire match_a  = rw_ok_a && (bus_addr == cmp_a);
  wire match_b  = rw_ok_b && (bus_addr == cmp_b);
  wire data_eq  = (bus_data == cmp_b[DW-1:0]);
  wire in_range = (bus_addr >= cmp_a) && (bus_addr <= cmp_b);
  wire is_event = (mode == M_EV_B) || (mode == M_EV_AB);
  wire live     = enable && bus_valid;

  logic cond;
  always_comb begin
    case (mode)
      M_A:      cond = match_a;
      M_A_OR_B: cond = match_a || match_b;
      M_A_THEN: cond = hit_a && match_b;
      M_FULL:   cond = match_a && data_eq;
      M_FULL_N: cond = match_a && !data_eq;
      M_EV_B:   cond = match_b;
      M_EV_AB:  cond = hit_a && match_b;
      M_IN:     cond = rw_ok_a && in_range;
      M_OUT:    cond = rw_ok_a && !in_range;
      default:  cond = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig         <= 1'b0;
      capture      <= 1'b0;
      capture_data <= '0;
      hit_a        <= 1'b0;
      hit_b        <= 1'b0;
    end else if (!enable) begin
      trig    <= 1'b0;
      capture <= 1'b0;
      hit_a   <= 1'b0;
      hit_b   <= 1'b0;
    end else begin
      trig    <= bus_valid && cond;
      capture <= bus_valid && cond && is_event;
      if (bus_valid && cond && is_event) capture_data <= bus_data;
      hit_a   <= hit_a || (bus_valid && match_a);
      hit_b   <= hit_b || (bus_valid && match_b);
    end
  end

  a_r1_no_strobe_no_trig: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> !trig && !capture);

  a_r2_need_prior_a: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_A_THEN && !hit_a) |=> !trig);

  a_r4_below_a_not_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IN && bus_addr < cmp_a) |=> !trig);

  a_r5_capture_implies_trig: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> trig);

  a_r5_capture_only_event: assert property (@(posedge clk) disable iff (!rst_n)
    !is_event |=> !capture);

  a_r7_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode > M_OUT) |=> !trig);

  a_r8_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !hit_a && !hit_b);

  a_r8_sticky_a: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && enable) |=> hit_a);

endmodule

// File: tb/test_bus_trigger_engine.sv
module test_bus_trigger_engine;
  localparam int AW = 4;
  localparam int DW = 3;

  logic clk = 0, rst_n = 0, enable = 0;
  logic [3:0] mode = 0;
  logic [AW-1:0] cmp_a = 0, cmp_b = 0, bus_addr = 0;
  logic qual_a_en = 0, qual_a_rd = 0, qual_b_en = 0, qual_b_rd = 0;
  logic bus_valid = 0, bus_rd = 0;
  logic [DW-1:0] bus_data = 0;
  logic trig, capture, hit_a, hit_b;
  logic [DW-1:0] capture_data;

  int checks = 0, fails = 0, cycles = 0;
  logic eha = 0, ehb = 0;

  always #2 clk = ~clk;

  bus_trigger_engine #(.AW(AW), .DW(DW)) i_bus_trigger_engine (
    .clk, .rst_n, .enable, .mode, .cmp_a, .cmp_b,
    .qual_a_en, .qual_a_rd, .qual_b_en, .qual_b_rd,
    .bus_valid, .bus_addr, .bus_data, .bus_rd,
    .trig, .capture, .capture_data, .hit_a, .hit_b);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: mode %0d a=%0d b=%0d addr=%0d data=%0d rd=%0d actual %0d expected %0d",
               tag, mode, cmp_a, cmp_b, bus_addr, bus_data, bus_rd, act, exp);
    end
  endtask

  function automatic string mode_tag(logic [3:0] m);
    case (m)
      0, 1: return "R1";
      2:    return "R2";
      3, 4: return "R3";
      5, 6: return "R5";
      7, 8: return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic step(logic v, logic [AW-1:0] a, logic [DW-1:0] d, logic rw);
    logic oka, okb, ma, mb, lo, hi, c, ev;
    logic [DW-1:0] cd;
    bus_valid = v; bus_addr = a; bus_data = d; bus_rd = rw;
    oka = !qual_a_en || rw == qual_a_rd;
    okb = !qual_b_en || rw == qual_b_rd;
    ma = oka && int'(a) == int'(cmp_a);
    mb = okb && int'(a) == int'(cmp_b);
    lo = int'(a) < int'(cmp_a);
    hi = int'(a) > int'(cmp_b);
    cd = cmp_b[DW-1:0];
    ev = (mode == 5 || mode == 6);
    case (mode)
      0: c = ma;
      1: c = ma | mb;
      2: c = eha & mb;
      3: c = ma && d == cd;
      4: c = ma && d != cd;
      5: c = mb;
      6: c = eha & mb;
      7: c = oka && !lo && !hi;
      8: c = oka && (lo || hi);
      default: c = 0;
    endcase
    c = c && v && enable;
    @(posedge clk); #1;
    chk(mode_tag(mode), {7'd0, trig}, {7'd0, c});
    chk("R5 capture", {7'd0, capture}, {7'd0, c && ev});
    if (c && ev) chk("R5 data", {5'd0, capture_data}, {5'd0, d});
    eha = enable && (eha || (v && ma));
    ehb = enable && (ehb || (v && mb));
    chk("R8 hit_a", {7'd0, hit_a}, {7'd0, eha});
    chk("R8 hit_b", {7'd0, hit_b}, {7'd0, ehb});
  endtask

  task automatic rearm();
    enable = 0;
    step(1, cmp_a, 0, 1);
    enable = 1;
  endtask

  initial begin
    #1;
    chk("R1 reset trig", {7'd0, trig}, 8'd0);
    chk("R8 reset flags", {6'd0, hit_a, hit_b}, 8'd0);
    #10 rst_n = 1;
    @(posedge clk); #1;

    // R6 directed: A qualified to reads only
    mode = 0; cmp_a = 5; cmp_b = 9; qual_a_en = 1; qual_a_rd = 1;
    rearm();
    step(1, 5, 0, 0);
    chk("R6 write blocked", {7'd0, trig}, 8'd0);
    step(1, 5, 0, 1);
    chk("R6 read passes", {7'd0, trig}, 8'd1);
    // R1: no strobe, no trigger
    step(0, 5, 0, 1);
    chk("R1 no strobe", {7'd0, trig}, 8'd0);
    qual_a_en = 0;

    for (int cfg = 0; cfg < 8; cfg++) begin
      case (cfg % 4)
        0: begin cmp_a = 3; cmp_b = 9;  end
        1: begin cmp_a = 9; cmp_b = 3;  end
        2: begin cmp_a = 6; cmp_b = 6;  end
        default: begin cmp_a = 0; cmp_b = 15; end
      endcase
      qual_a_en = cfg >= 4; qual_a_rd = 1;
      qual_b_en = cfg >= 4; qual_b_rd = 0;
      for (int m = 0; m < 16; m++) begin
        mode = 4'(m);
        rearm();
        for (int ad = 0; ad < 16; ad++)
          for (int dt = 0; dt < 8; dt++)
            for (int rw = 0; rw < 2; rw++)
              step(((ad + dt) % 7) != 6, 4'(ad), 3'(dt), rw[0]);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule